// File: doc/BRIEF.md
# Stall-Buffered Router for a Stacked 3-D Mesh

This block is one node of a packet network laid out as a three-dimensional mesh of stacked layers. Each cycle it takes whole packets from up to seven ports (the attached node, four in-layer neighbours and up to two vertical neighbours). For every packet it picks one output port, and it sends at most one packet out of each port. The choice is made in the same cycle. Inputs use a valid/ready handshake. Outputs carry only a valid strobe, because the neighbour always takes a packet it is offered. Outputs are combinational from the inputs and the buffer state.

A packet that loses its preferred port is parked in a small shared buffer of stalled packets. Parked packets compete first on every later cycle, oldest first. When the buffer has no room left, a losing packet is deflected through any free neighbour port, so that no packet is dropped. Parameters select the coordinate of this node, the port variant (in-layer only, plus up, plus down, or both vertical directions) and a mask that switches off ports with no neighbour.

The buffer occupancy is tracked by a three-state machine. SB_EMPTY moves to SB_PARTIAL on a first park, or to SB_FULL on a burst fill. SB_PARTIAL moves to SB_FULL on a top-up, and back to SB_EMPTY when it drains. SB_FULL moves to SB_PARTIAL on a release, or to SB_EMPTY when it drains. The machine stays where it is when the occupancy does not cross a boundary.

Top module: `mesh_router3d`

## Requirements
- R1: After reset the stall buffer is empty, and with no input valid every out_valid and in_ready bit is 0.
- R2: Port indices are 0 local, 1 X-minus, 2 X-plus, 3 Y-minus, 4 Y-plus, 5 Z-up, 6 Z-down. The packet fields are x in [2:0], y in [5:3], z in [8:6], hop in [12:9] and payload in [20:13]. The preferred port compares the destination with the own coordinate in this order: a larger z goes to port 5 and a smaller z to port 6 (when that port exists); then a larger x goes to port 2 and a smaller x to port 1; then a larger y goes to port 4 and a smaller y to port 3. An equal coordinate goes to port 0.
- R3: Each output port carries at most one packet per cycle. An input packet that cannot get its preferred port, while the buffer has room, is accepted (in_ready high) and parked instead of being forwarded.
- R4: Parked packets are allocated before any input packet, in the order in which they were parked. A parked packet stays in the buffer until its preferred port is free.
- R5: When an input packet cannot get its preferred port and the buffer has no room, it leaves on the lowest-numbered free port in the range 1 to 6 other than its arrival port.
- R6: No packet ever leaves on the port it arrived on. A packet whose preferred port is its arrival port is parked or deflected.
- R7: Every packet that leaves has its hop field incremented by one, modulo 16.
- R8: in_ready is high only for a valid input that is forwarded, parked or deflected. It is low when none of these is possible.
- R9: Disabled ports (masked by the parameter, or absent in the chosen variant) never assert in_ready or out_valid. The in-layer variant has no ports 5 and 6.
- R10: The buffer holds DEPTH_3D packets in the vertical variants and DEPTH_3D + ceil(0.3·DEPTH_3D) in the in-layer variant, so 4 and 6 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 7 | Packet offered on each input port |
| in_ready | output | 7 | Packet taken on each input port this cycle |
| in_pkt | input | 7×21 | Packet on each input port |
| out_valid | output | 7 | Packet leaving on each output port |
| out_pkt | output | 7×21 | Packet leaving on each output port, hop already incremented |

## Verification
A wrong buffer state appears at the ports in the very next cycle. A lost or duplicated parked packet shows up as a missing or extra out_valid once its preferred port frees. A wrong occupancy flips in_ready, or causes a deflection one cycle too early or too late. The bench therefore compares every output and ready bit on every cycle against a queue model. Directed patterns fill the buffer with packets that can never leave, which forces deflection and back-pressure at known cycles.

// File: rtl/mr3_pkg.sv
package mr3_pkg;
    localparam int NPORT  = 7;
    localparam int P_LOCAL = 0;
    localparam int P_XN    = 1;
    localparam int P_XP    = 2;
    localparam int P_YN    = 3;
    localparam int P_YP    = 4;
    localparam int P_ZUP   = 5;
    localparam int P_ZDN   = 6;

    typedef logic [2:0] port_t;

    typedef enum logic [1:0] {
        SB_EMPTY,
        SB_PARTIAL,
        SB_FULL
    } sb_state_e;
endpackage

// File: rtl/mr3_route_compute.sv
module mr3_route_compute
    import mr3_pkg::*;
#(
    parameter int CW = 3,
    parameter int OWN_X = 2,
    parameter int OWN_Y = 2,
    parameter int OWN_Z = 2,
    parameter logic [NPORT-1:0] EN = '1
) (
    input  logic [CW-1:0] dst_x,
    input  logic [CW-1:0] dst_y,
    input  logic [CW-1:0] dst_z,
    output port_t         pref
);
    localparam logic [CW-1:0] OX = CW'(OWN_X);
    localparam logic [CW-1:0] OY = CW'(OWN_Y);
    localparam logic [CW-1:0] OZ = CW'(OWN_Z);

    // vertical first when that link exists, then X, then Y (R2)
    always_comb begin
        if (dst_z > OZ && EN[P_ZUP])       pref = port_t'(P_ZUP);
        else if (dst_z < OZ && EN[P_ZDN])  pref = port_t'(P_ZDN);
        else if (dst_x > OX)               pref = port_t'(P_XP);
        else if (dst_x < OX)               pref = port_t'(P_XN);
        else if (dst_y > OY)               pref = port_t'(P_YP);
        else if (dst_y < OY)               pref = port_t'(P_YN);
        else if (dst_z == OZ)              pref = port_t'(P_LOCAL);
        else                               pref = (dst_z > OZ) ? port_t'(P_ZUP) : port_t'(P_ZDN);
    end
endmodule

// File: rtl/mr3_stall_buffer.sv
module mr3_stall_buffer
    import mr3_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int PKT_W = 21
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [DEPTH-1:0]              served,
    input  logic [NPORT-1:0]              push,
    input  logic [NPORT-1:0][PKT_W-1:0]   push_pkt,
    output logic [DEPTH-1:0]              sb_v,
    output logic [DEPTH-1:0][PKT_W-1:0]   sb_pkt,
    output port_t [DEPTH-1:0]             sb_arr,
    output logic                          sb_full
);
    logic [DEPTH-1:0]            nxt_v;
    logic [DEPTH-1:0][PKT_W-1:0] nxt_pkt;
    port_t [DEPTH-1:0]           nxt_arr;
    sb_state_e                   state_q, state_d;
    int                          fill;

    // compaction keeps parking order: survivors first, then new entries by port (R4)
    always_comb begin
        fill    = 0;
        nxt_v   = '0;
        nxt_pkt = sb_pkt;
        nxt_arr = sb_arr;
        for (int i = 0; i < DEPTH; i++) begin
            if (sb_v[i] && !served[i]) begin
                for (int j = 0; j < DEPTH; j++) begin
                    if (j == fill) begin
                        nxt_v[j]   = 1'b1;
                        nxt_pkt[j] = sb_pkt[i];
                        nxt_arr[j] = sb_arr[i];
                    end
                end
                fill = fill + 1;
            end
        end
        for (int p = 0; p < NPORT; p++) begin
            if (push[p]) begin
                for (int j = 0; j < DEPTH; j++) begin
                    if (j == fill) begin
                        nxt_v[j]   = 1'b1;
                        nxt_pkt[j] = push_pkt[p];
                        nxt_arr[j] = port_t'(p);
                    end
                end
                fill = fill + 1;
            end
        end
        if (fill == 0)           state_d = SB_EMPTY;
        else if (fill >= DEPTH)  state_d = SB_FULL;
        else                     state_d = SB_PARTIAL;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SB_EMPTY;
            sb_v    <= '0;
            sb_pkt  <= '0;
            sb_arr  <= '0;
        end else begin
            state_q <= state_d;
            sb_v    <= nxt_v;
            sb_pkt  <= nxt_pkt;
            sb_arr  <= nxt_arr;
        end
    end

    // outputs from state
    always_comb begin
        unique case (state_q)
            SB_EMPTY:   sb_full = 1'b0;
            SB_PARTIAL: sb_full = 1'b0;
            SB_FULL:    sb_full = 1'b1;
            default:    sb_full = 1'b0;
        endcase
    end

    AST_PUSH_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(push) <= DEPTH - $countones(sb_v & ~served)); // R10
    AST_FULL_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        sb_full == (&sb_v)); // R10
endmodule

// File: rtl/mr3_port_arbiter.sv
module mr3_port_arbiter
    import mr3_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int NC = 11,
    parameter int CIW = 4,
    parameter logic [NPORT-1:0] EN = '1
) (
    input  logic [NC-1:0]     cand_v,
    input  port_t [NC-1:0]    cand_pref,
    input  port_t [NC-1:0]    cand_arr,
    output logic [DEPTH-1:0]  served,
    output logic [NPORT-1:0]  push,
    output logic [NPORT-1:0]  in_ready,
    output logic [NPORT-1:0]  deflect,
    output logic [NPORT-1:0]  out_v,
    output logic [CIW-1:0]    out_sel [NPORT]
);
    logic [NPORT-1:0] busy;
    int               room;
    logic             hit;
    port_t            pr;

    always_comb begin
        busy     = ~EN;
        served   = '0;
        push     = '0;
        in_ready = '0;
        deflect  = '0;
        out_v    = '0;
        hit      = 1'b0;
        pr       = '0;
        for (int q = 0; q < NPORT; q++) out_sel[q] = '0;
        room = DEPTH;
        // parked packets first (R4)
        for (int c = 0; c < DEPTH; c++) begin
            if (cand_v[c]) begin
                pr = cand_pref[c];
                if (!busy[pr] && pr != cand_arr[c]) begin
                    busy[pr]    = 1'b1;
                    out_v[pr]   = 1'b1;
                    out_sel[pr] = CIW'(c);
                    served[c]   = 1'b1;
                end else begin
                    room = room - 1;
                end
            end
        end
        // arriving packets: forward, park, deflect, or refuse
        for (int p = 0; p < NPORT; p++) begin
            if (cand_v[DEPTH+p]) begin
                pr = cand_pref[DEPTH+p];
                if (!busy[pr] && pr != port_t'(p)) begin
                    busy[pr]    = 1'b1;
                    out_v[pr]   = 1'b1;
                    out_sel[pr] = CIW'(DEPTH + p);
                    in_ready[p] = 1'b1;
                end else if (room > 0) begin
                    push[p]     = 1'b1;
                    in_ready[p] = 1'b1;
                    room        = room - 1;
                end else begin
                    hit = 1'b0;
                    for (int q = 1; q < NPORT; q++) begin
                        if (!hit && !busy[q] && q != p) begin
                            hit         = 1'b1;
                            busy[q]     = 1'b1;
                            out_v[q]    = 1'b1;
                            out_sel[q]  = CIW'(DEPTH + p);
                            deflect[p]  = 1'b1;
                            in_ready[p] = 1'b1;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/mesh_router3d.sv
module mesh_router3d
    import mr3_pkg::*;
#(
    parameter int CW = 3,
    parameter int HW = 4,
    parameter int PW = 8,
    parameter int OWN_X = 2,
    parameter int OWN_Y = 2,
    parameter int OWN_Z = 2,
    parameter int VARIANT = 3,
    parameter logic [NPORT-1:0] PORT_EN = '1,
    parameter int DEPTH_3D = 4,
    localparam int PKT_W = 3 * CW + HW + PW
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NPORT-1:0]             in_valid,
    output logic [NPORT-1:0]             in_ready,
    input  logic [NPORT-1:0][PKT_W-1:0]  in_pkt,
    output logic [NPORT-1:0]             out_valid,
    output logic [NPORT-1:0][PKT_W-1:0]  out_pkt
);
    localparam logic [NPORT-1:0] VMASK = (VARIANT == 0) ? 7'h1F :
                                         (VARIANT == 1) ? 7'h3F :
                                         (VARIANT == 2) ? 7'h5F : 7'h7F;
    localparam logic [NPORT-1:0] EN = PORT_EN & VMASK;
    localparam int SB_DEPTH = (VARIANT == 0) ? DEPTH_3D + (DEPTH_3D * 3 + 9) / 10 : DEPTH_3D;
    localparam int NC = SB_DEPTH + NPORT;
    localparam int CIW = $clog2(NC);
    localparam int HOP_LO = 3 * CW;

    logic [SB_DEPTH-1:0]            sb_v;
    logic [SB_DEPTH-1:0][PKT_W-1:0] sb_pkt;
    port_t [SB_DEPTH-1:0]           sb_arr;
    logic                           sb_full;
    logic [SB_DEPTH-1:0]            served;
    logic [NPORT-1:0]               push;
    logic [NPORT-1:0]               deflect;
    logic [NC-1:0]                  cand_v;
    logic [NC-1:0][PKT_W-1:0]       cand_pkt;
    port_t [NC-1:0]                 cand_pref;
    port_t [NC-1:0]                 cand_arr;
    logic [CIW-1:0]                 out_sel [NPORT];
    logic [PKT_W-1:0]               pk_tmp;

    assign cand_v   = {in_valid & EN, sb_v};
    assign cand_pkt = {in_pkt, sb_pkt};

    genvar g;
    generate
        for (g = 0; g < SB_DEPTH; g++) begin : g_sb_arr
            assign cand_arr[g] = sb_arr[g];
        end
        for (g = 0; g < NPORT; g++) begin : g_in_arr
            assign cand_arr[SB_DEPTH+g] = port_t'(g);
        end
        for (g = 0; g < NC; g++) begin : g_route
            mr3_route_compute #(
                .CW(CW), .OWN_X(OWN_X), .OWN_Y(OWN_Y), .OWN_Z(OWN_Z), .EN(EN)
            ) u_rc (
                .dst_x (cand_pkt[g][CW-1:0]),
                .dst_y (cand_pkt[g][2*CW-1:CW]),
                .dst_z (cand_pkt[g][3*CW-1:2*CW]),
                .pref  (cand_pref[g])
            );
        end
    endgenerate

    mr3_stall_buffer #(.DEPTH(SB_DEPTH), .PKT_W(PKT_W)) u_sb (
        .clk      (clk),
        .rst_n    (rst_n),
        .served   (served),
        .push     (push),
        .push_pkt (in_pkt),
        .sb_v     (sb_v),
        .sb_pkt   (sb_pkt),
        .sb_arr   (sb_arr),
        .sb_full  (sb_full)
    );

    mr3_port_arbiter #(.DEPTH(SB_DEPTH), .NC(NC), .CIW(CIW), .EN(EN)) u_arb (
        .cand_v    (cand_v),
        .cand_pref (cand_pref),
        .cand_arr  (cand_arr),
        .served    (served),
        .push      (push),
        .in_ready  (in_ready),
        .deflect   (deflect),
        .out_v     (out_valid),
        .out_sel   (out_sel)
    );

    // output mux with hop increment (R7)
    always_comb begin
        pk_tmp = '0;
        for (int q = 0; q < NPORT; q++) begin
            pk_tmp = cand_pkt[out_sel[q]];
            pk_tmp[HOP_LO +: HW] = pk_tmp[HOP_LO +: HW] + HW'(1);
            out_pkt[q] = out_valid[q] ? pk_tmp : '0;
        end
    end

    generate
        for (g = 0; g < NPORT; g++) begin : g_chk
            AST_NO_U_TURN: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid[g] |-> cand_arr[out_sel[g]] != port_t'(g)); // R6
        end
    endgenerate

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_valid | in_ready) & ~EN) == '0); // R9
    AST_DEFLECT_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (|deflect) |-> ($countones(push) + $countones(sb_v & ~served) == SB_DEPTH)); // R5
    AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready & ~in_valid) == '0); // R8
    AST_FULL_BLOCKS_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_full && served == '0) |-> push == '0); // R10
endmodule

// File: tb/mesh_router3d_test.sv
module mesh_router3d_test;
    localparam int CLK_P = 10;
    localparam int PKW = 21;
    localparam int DEPTH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    logic [6:0] iv, ird, ov, fiv, fird, fov;
    logic [6:0][PKW-1:0] ipk, opk, fipk, fopk;

    mesh_router3d uut (
        .clk(clk), .rst_n(rst_n), .in_valid(iv), .in_ready(ird),
        .in_pkt(ipk), .out_valid(ov), .out_pkt(opk)
    );
    mesh_router3d #(.VARIANT(0)) uut_flat (
        .clk(clk), .rst_n(rst_n), .in_valid(fiv), .in_ready(fird),
        .in_pkt(fipk), .out_valid(fov), .out_pkt(fopk)
    );

    int checks = 0, errors = 0, ndefl = 0, nblock = 0;
    bit done = 0;

    typedef struct { logic [PKW-1:0] pkt; int arr; } ent_t;
    ent_t sq[$];

    function automatic logic [PKW-1:0] mk(int x, int y, int z, int hop, int pay);
        return {8'(pay), 4'(hop), 3'(z), 3'(y), 3'(x)};
    endfunction

    function automatic int pref(logic [PKW-1:0] p);
        int x = int'(p[2:0]);
        int y = int'(p[5:3]);
        int z = int'(p[8:6]);
        if (z > 2) return 5;
        if (z < 2) return 6;
        if (x > 2) return 2;
        if (x < 2) return 1;
        if (y > 2) return 4;
        if (y < 2) return 3;
        return 0;
    endfunction

    function automatic logic [PKW-1:0] inc(logic [PKW-1:0] p);
        logic [PKW-1:0] r = p;
        r[12:9] = r[12:9] + 4'd1;
        return r;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // queue model of one cycle, compared and committed
    task automatic step(string tag);
        logic [6:0] busy = '0, eov = '0, erdy = '0;
        logic [6:0][PKW-1:0] epk = '0;
        ent_t keep[$];
        int room, pr;
        bit got;
        #1;
        foreach (sq[i]) begin
            pr = pref(sq[i].pkt);
            if (!busy[pr] && pr != sq[i].arr) begin
                busy[pr] = 1'b1; eov[pr] = 1'b1; epk[pr] = inc(sq[i].pkt);
            end else keep.push_back(sq[i]);
        end
        room = DEPTH - keep.size();
        for (int p = 0; p < 7; p++) begin
            if (iv[p]) begin
                pr = pref(ipk[p]);
                if (!busy[pr] && pr != p) begin
                    busy[pr] = 1'b1; eov[pr] = 1'b1; epk[pr] = inc(ipk[p]); erdy[p] = 1'b1;
                end else if (room > 0) begin
                    keep.push_back('{ipk[p], p}); room--; erdy[p] = 1'b1;
                end else begin
                    got = 0;
                    for (int q = 1; q < 7; q++) begin
                        if (!got && !busy[q] && q != p) begin
                            got = 1; busy[q] = 1'b1; eov[q] = 1'b1; epk[q] = inc(ipk[p]);
                            erdy[p] = 1'b1; ndefl++;
                        end
                    end
                    if (!got) nblock++;
                end
            end
        end
        chk(ird === erdy, {tag, " ready"}, 32'(ird), 32'(erdy));
        chk(ov === eov, {tag, " out_valid"}, 32'(ov), 32'(eov));
        for (int q = 0; q < 7; q++)
            if (eov[q]) chk(opk[q] === epk[q], {tag, " out_pkt"}, 32'(opk[q]), 32'(epk[q]));
        sq = keep;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; iv = '0; fiv = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        sq.delete();
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int ep[9];
        int dst[9][4];
        iv = '0; fiv = '0; ipk = '0; fipk = '0;
        do_reset();
        // R1: idle after reset
        chk(ov == 7'h0 && ird == 7'h0, "R1 reset", 32'(ov), 0);
        repeat (3) step("R1");

        // R9 and R10 on the in-layer variant: stuck packets fill 6 slots, 7th deflects
        for (int k = 0; k < 7; k++) begin
            fiv = '0; fiv[1] = 1'b1; fiv[5] = 1'b1;
            fipk[1] = mk(0, 2, 2, 0, k); fipk[5] = mk(2, 2, 2, 0, k);
            #1;
            chk(fird[5] == 1'b0 && fov[6:5] == 2'b00, "R9 disabled vertical", 32'({fird[5], fov[6:5]}), 0);
            if (k < 6) chk(fov == 7'h0 && fird[1], "R10 park in-layer", 32'(fov), 0);
            else       chk(fov == 7'b0000100 && fird[1], "R10 deflect after 6", 32'(fov), 32'h4);
            step("R1");
        end
        fiv = '0;

        // R2: direction choice from the local port
        dst = '{'{2,2,3,0}, '{2,2,1,0}, '{3,2,2,0}, '{1,2,2,0}, '{2,3,2,0},
                '{2,1,2,0}, '{3,3,3,0}, '{3,3,2,0}, '{2,2,2,1}};
        ep = '{5, 6, 2, 1, 4, 3, 5, 2, 0};
        for (int i = 0; i < 9; i++) begin
            iv = '0; iv[dst[i][3]] = 1'b1;
            ipk[dst[i][3]] = mk(dst[i][0], dst[i][1], dst[i][2], 0, i);
            #1;
            chk(ov == 7'(1 << ep[i]), "R2 direction", 32'(ov), 32'(1 << ep[i]));
            step("R2");
        end

        // R7: hop increments
        iv = 7'h01; ipk[0] = mk(3, 2, 2, 5, 8'hA5);
        #1;
        chk(opk[2][12:9] == 4'd6, "R7 hop", 32'(opk[2][12:9]), 6);
        step("R7");

        // R3: all ports want X-plus
        iv = 7'h7F;
        for (int p = 0; p < 7; p++) ipk[p] = mk(3, 2, 2, 0, p);
        #1;
        chk(ird == 7'h7F && ov == 7'b0001110, "R3 one per output", 32'(ov), 32'h0E);
        step("R3");
        // R4: parked packet from port 1 wins over new arrival
        iv = 7'h01; ipk[0] = mk(3, 2, 2, 0, 8'h44);
        #1;
        chk(ov == 7'b0000100 && opk[2][20:13] == 8'd1, "R4 parked first", 32'(opk[2][20:13]), 1);
        step("R4");
        iv = '0;
        repeat (6) step("R4");

        // R6: packet from X-plus bound for X-plus is parked, never turned back
        do_reset();
        for (int k = 0; k < 4; k++) begin
            iv = 7'h04; ipk[2] = mk(3, 2, 2, 0, k);
            #1;
            chk(ov == 7'h0 && ird[2], "R6 no u-turn", 32'(ov), 0);
            step("R6");
        end
        // R5 R8: buffer full of stuck packets
        iv = 7'h7F;
        for (int p = 0; p < 7; p++) ipk[p] = mk(3, 2, 2, 0, 16 + p);
        #1;
        chk(ird == 7'b0111111, "R8 refuse", 32'(ird), 32'h3F);
        chk(ov == 7'b1111110, "R5 deflect order", 32'(ov), 32'h7E);
        step("R5 R8");
        iv = '0;

        // random traffic compared against the model
        do_reset();
        for (int n = 0; n < 3000; n++) begin
            for (int p = 0; p < 7; p++) begin
                logic [PKW-1:0] pk;
                iv[p] = 1'($urandom % 2);
                do pk = mk($urandom % 5, $urandom % 5, $urandom % 5, $urandom % 16, $urandom % 256);
                while (pref(pk) == p);
                ipk[p] = pk;
            end
            step("R5 R7 random");
        end
        iv = '0;
        chk(ndefl > 0, "R5 deflections seen", 32'(ndefl), 1);
        chk(nblock > 0, "R8 refusals seen", 32'(nblock), 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule